// File: doc/BRIEF.md
# Dual-Input Non-Retriggerable Digital One-Shot

This block is a clocked monostable. When it is triggered, it drives a single output pulse whose length is a whole number of clock cycles. There are two trigger inputs. The first is an active-low input, `trig_a_n`, which fires on its falling edge while `trig_b` is high. The second is an active-high input, `trig_b`, which fires on its rising edge while `trig_a_n` is low. Holding either input at its idle level blocks the other input. The pulse length is taken from the `width` input in the cycle the trigger is accepted, so the length does not depend on how long the trigger stays active.

An active-low clear, `clr_n`, overrides everything. While it is low, `q` is low and `q_n` is high, and any pulse in progress stops. An internal arming flag decides whether releasing clear with the inputs already in the firing condition starts a pulse. The flag is set while clear is inactive and either `trig_a_n` is high or `trig_b` is low. Firing a pulse clears the flag. All three control inputs go through a two-flop synchronizer before any decision is made. A second channel is built as a second instance of this block.

Top module: `oneshot_dual_trig`

## Requirements
- R1: With `trig_b` high and clear inactive, a falling edge on `trig_a_n` starts a pulse. `q` rises on the third rising clock edge after the input change.
- R2: With `trig_a_n` low and clear inactive, a rising edge on `trig_b` starts a pulse, with the same latency as R1.
- R3: While `trig_a_n` is high, edges on `trig_b` produce no pulse. While `trig_b` is low, edges on `trig_a_n` produce no pulse.
- R4: Once a pulse has started, edges on either trigger input do not restart or extend it.
- R5: While the synchronized clear is low, `q` is 0 and `q_n` is 1. Driving clear low during a pulse ends that pulse three edges after the input change.
- R6: Releasing clear with `trig_a_n` low and `trig_b` high starts a pulse if the arming flag was set before clear went low. The flag is set when clear is high and either `trig_a_n` is high or `trig_b` is low.
- R7: Firing clears the arming flag. Releasing clear after a pulse, with the inputs left in the firing condition the whole time, produces no pulse.
- R8: `width` is sampled only in the cycle the trigger is accepted. Changing `width` afterwards, or ending the trigger early, does not change the pulse length.
- R9: `width` is an unsigned cycle count. `q` stays high for exactly `width` cycles, and a value of 0 gives one cycle. The largest value, 255, gives 255 cycles.
- R10: `q_n` is always the complement of `q`. After reset, `q` is 0, `q_n` is 1 and the arming flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low clear; forces the output idle and can fire on release |
| trig_a_n | input | 1 | Active-low trigger; fires on a falling edge |
| trig_b | input | 1 | Active-high trigger; fires on a rising edge |
| width | input | WIDTH_BITS (8) | Pulse length in clock cycles, sampled when the trigger is accepted |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of `q` |

## Verification
The bound checker watches several properties on every cycle:
- that `q_n` always complements `q`;
- that a low synchronized clear forces the output idle;
- that the counter only counts down during a pulse, so it is never reloaded;
- that every rising `q` followed a synchronized firing condition and a set arming flag, which is then cleared;
- that the loaded count matches the sampled width.

Other behaviours only the bench's scenarios can show: the exact three-edge latency, the exact pulse lengths including the abort-by-clear length, the absence of any pulse under inhibit, and the absence of a pulse when clear is released unarmed.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronized view of the three control inputs (raw polarity kept)
    typedef struct packed {
        logic clr_n;
        logic a_n;
        logic b;
    } ctl_t;

    // Trigger qualifier state
    typedef struct packed {
        ctl_t prev;
        logic armed;
    } qual_state_t;

    // Firing condition on the input levels: A low and B high
    function automatic logic fire_level(input ctl_t c);
        return (!c.a_n) && c.b;
    endfunction

    // Arming condition: clear inactive and an input at its idle level
    function automatic logic arm_level(input ctl_t c);
        return c.clr_n && (c.a_n || !c.b);
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    // One flop row per stage
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= '0;
                end else begin
                    chain_q[g] <= chain_d[g];
                end
            end
        end
    endgenerate

    assign dout = chain_q[LAST];
endmodule

// File: rtl/os_qualifier.sv
module os_qualifier
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t cur,
    input  logic busy,
    output logic fire,
    output logic armed
);
    qual_state_t st_d, st_q;
    logic        fresh;
    logic        fire_d;

    always_comb begin
        st_d = st_q;
        // The previous cycle was not already "clear high with firing levels"
        fresh  = st_q.prev.a_n || !st_q.prev.b || !st_q.prev.clr_n;
        fire_d = cur.clr_n && !busy && st_q.armed && fire_level(cur) && fresh;

        if (arm_level(cur)) begin
            st_d.armed = 1'b1;
        end else if (fire_d) begin
            st_d.armed = 1'b0;
        end
        st_d.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire  = fire_d;
    assign armed = st_q.armed;
endmodule

// File: rtl/os_timer.sv
module os_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_ok,
    input  logic          fire,
    input  logic [CW-1:0] width,
    output logic          q,
    output logic          q_n,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic          q;
        logic          q_n;
        logic [CW-1:0] cnt;
    } tmr_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!clr_ok) begin
            t_d.q   = 1'b0;
            t_d.q_n = 1'b1;
            t_d.cnt = '0;
        end else if (fire) begin
            t_d.q   = 1'b1;
            t_d.q_n = 1'b0;
            t_d.cnt = (width == '0) ? '0 : width - ONE;
        end else if (t_q.q) begin
            if (t_q.cnt == '0) begin
                t_d.q   = 1'b0;
                t_d.q_n = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{q: 1'b0, q_n: 1'b1, cnt: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign q   = t_q.q;
    assign q_n = t_q.q_n;
    assign cnt = t_q.cnt;
endmodule

// File: rtl/oneshot_dual_trig.sv
module oneshot_dual_trig
    import oneshot_pkg::*;
#(
    parameter int WIDTH_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  trig_a_n,
    input  logic                  trig_b,
    input  logic [WIDTH_BITS-1:0] width,
    output logic                  q,
    output logic                  q_n
);
    localparam int CTL_W = $bits(ctl_t);

    ctl_t                  raw;
    ctl_t                  s_ctl;
    logic [CTL_W-1:0]      s_vec;
    logic                  fire;
    logic                  armed;
    logic [WIDTH_BITS-1:0] cnt;
    logic                  s_a;
    logic                  s_b;
    logic                  s_c;

    assign raw = '{clr_n: clr_n, a_n: trig_a_n, b: trig_b};

    os_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (s_vec)
    );

    assign s_ctl = ctl_t'(s_vec);
    assign s_a   = s_ctl.a_n;
    assign s_b   = s_ctl.b;
    assign s_c   = s_ctl.clr_n;

    os_qualifier u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (s_ctl),
        .busy (q),
        .fire (fire),
        .armed(armed)
    );

    os_timer #(.CW(WIDTH_BITS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_ok(s_c),
        .fire  (fire),
        .width (width),
        .q     (q),
        .q_n   (q_n),
        .cnt   (cnt)
    );
endmodule

// File: rtl/oneshot_dual_trig_chk.sv
module oneshot_dual_trig_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] width,
    input logic          q,
    input logic          q_n,
    input logic          armed,
    input logic [CW-1:0] cnt,
    input logic          sa,
    input logic          sb,
    input logic          sc
);
    // R10
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_n == !q);

    // R5
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc |=> (!q && q_n));

    // R4
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && $past(q)) |-> (cnt == CW'($past(cnt) - 1)));

    // R3
    fire_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> (!$past(sa) && $past(sb) && $past(sc)));

    // R6
    armed_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(armed));

    // R7
    disarm_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> !armed);

    // R9
    width_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> (cnt == (($past(width) == '0) ? '0 : CW'($past(width) - 1))));
endmodule

bind oneshot_dual_trig oneshot_dual_trig_chk #(.CW(WIDTH_BITS)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .width(width),
    .q    (q),
    .q_n  (q_n),
    .armed(armed),
    .cnt  (cnt),
    .sa   (s_a),
    .sb   (s_b),
    .sc   (s_c)
);

// File: tb/oneshot_dual_trig_bench.sv
module oneshot_dual_trig_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       trig_a_n = 1'b1;
    logic       trig_b = 1'b1;
    logic [7:0] width = 8'd5;
    logic       q;
    logic       q_n;

    always #4 clk = ~clk;

    oneshot_dual_trig u_oneshot_dual_trig (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .trig_a_n(trig_a_n),
        .trig_b(trig_b), .width(width), .q(q), .q_n(q_n)
    );

    typedef struct {
        int    rise;
        int    len;
        string req;
    } exp_t;

    exp_t expq[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   rise_at = 0;
    logic prev_q = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: the input change was just driven at this negedge
    task automatic expect_pulse(input int len, input string req);
        exp_t e;
        e.rise = cyc + 3;
        e.len  = len;
        e.req  = req;
        expq.push_back(e);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(q_n == !q, "R10", "q_n vs q", int'(q_n), int'(!q));
            if (q && !prev_q) rise_at = cyc;
            if (!q && prev_q) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R3/R7", "unexpected pulse at cycle", rise_at, -1);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(rise_at == e.rise, e.req, "pulse start cycle", rise_at, e.rise);
                    check(cyc - rise_at == e.len, e.req, "pulse length", cyc - rise_at, e.len);
                end
            end
            prev_q = q;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", "run expired", 0, 1);
            summary();
        end
    end

    initial begin
        step(4);
        // R10: reset state
        check(q == 1'b0 && q_n == 1'b1, "R10", "reset q/q_n", {q, q_n}, 2'b01);
        rst_n = 1'b1;
        step(4);

        // R1: falling A with B high
        trig_a_n = 1'b0; expect_pulse(5, "R1");
        step(12);
        trig_a_n = 1'b1; step(4);

        // R2: rising B with A low (A falls while B low: inhibited)
        trig_b = 1'b0; step(4);
        width = 8'd3;
        trig_a_n = 1'b0; step(4);
        trig_b = 1'b1; expect_pulse(3, "R2");
        step(10);

        // R3: inhibit by B low, then by A high
        trig_b = 1'b0; step(4);
        trig_a_n = 1'b1; step(4);
        trig_a_n = 1'b0; step(4);
        trig_a_n = 1'b1; step(4);
        trig_b = 1'b1; step(4);
        trig_b = 1'b0; step(4);
        trig_b = 1'b1; step(6);
        check(q == 1'b0, "R3", "q after inhibited edges", int'(q), 0);

        // R4: edges during a pulse are ignored
        width = 8'd20;
        trig_a_n = 1'b0; expect_pulse(20, "R4");
        step(4);
        trig_a_n = 1'b1; step(2);
        trig_a_n = 1'b0; step(2);
        trig_a_n = 1'b1; step(2);
        trig_a_n = 1'b0; step(2);
        trig_b = 1'b0; step(2);
        trig_b = 1'b1; step(20);
        trig_a_n = 1'b1; step(4);

        // R9: width zero gives one cycle
        width = 8'd0;
        trig_a_n = 1'b0; expect_pulse(1, "R9");
        step(4);
        width = 8'd7; step(6);
        trig_a_n = 1'b1; step(4);

        // R8: short trigger, width changed after acceptance
        width = 8'd10;
        trig_a_n = 1'b0; expect_pulse(10, "R8");
        step(2);
        trig_a_n = 1'b1; step(3);
        width = 8'd2; step(12);

        // R9: maximum width
        width = 8'd255;
        trig_a_n = 1'b0; expect_pulse(255, "R9");
        step(260);
        trig_a_n = 1'b1; step(4);

        // R5: clear aborts a pulse after 8 cycles
        width = 8'd40;
        trig_a_n = 1'b0; expect_pulse(8, "R5");
        step(8);
        clr_n = 1'b0; step(4);
        check(q == 1'b0 && q_n == 1'b1, "R5", "q/q_n under clear", {q, q_n}, 2'b01);

        // R6: arm, hold clear, move to firing levels, release
        trig_a_n = 1'b1; step(4);
        clr_n = 1'b1; step(4);
        clr_n = 1'b0; step(4);
        trig_a_n = 1'b0; step(4);
        check(q == 1'b0, "R5", "no pulse while clear low", int'(q), 0);
        width = 8'd6;
        clr_n = 1'b1; expect_pulse(6, "R6");
        step(12);

        // R7: unarmed clear release gives nothing
        clr_n = 1'b0; step(4);
        clr_n = 1'b1; step(12);
        check(q == 1'b0, "R7", "q after unarmed release", int'(q), 0);

        step(4);
        check(expq.size() == 0, "R1", "pending expected pulses", expq.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule